// File: doc/BRIEF.md
# Serial Ethernet Receive Frame Checker

This block watches a received Ethernet frame one bit per clock, least significant bit of each octet first, starting with the first bit after the start-of-frame delimiter. A frame is the run of consecutive cycles in which `rx_valid` is high. While the frame streams in, the block runs a CRC-32 over it and counts its bits. When `rx_valid` drops, it judges the frame and reports the result on a one-cycle `done` strobe. The strobe carries the octet count, the number of trailing dribble bits, and flags for a CRC error, a non-octet-aligned error, and a short frame.

Up to seven bits past the last whole octet are tolerated. The CRC verdict always comes from the register value held at the last whole-octet boundary, so those dribble bits never affect it. A bad CRC is reported as an alignment error when dribble bits are present and as a CRC error when the frame is aligned. A good CRC with dribble bits reports nothing.

Two saturating counters keep the CRC and alignment error totals. A hunt indication is raised after any frame with a bad CRC and drops when the next frame begins. Frames shorter than a programmable minimum are silently dropped unless short-frame reception is enabled. CRC checking has no enable.

Top module: `rxchk_frame_checker`

## Requirements
- R1: A frame ends at the first rising clock edge with `rx_valid` low after one or more edges with it high. At that edge `done` goes high for exactly one cycle, with `frame_octets` = whole octets received and `dribble` = leftover bits (0..7).
- R2: The CRC is CRC-32 with the reflected polynomial 0xEDB88320, shifted LSB first and preset to all ones. A frame passes when the register at its last whole-octet boundary equals 0xDEBB20E3, the bit-reversed form of residue 0xC704DD7B. This holds when the last four octets are the complemented CRC of the preceding octets, low octet first.
- R3: An aligned frame (`dribble`=0) with a failing CRC closes with `err_crc`=1 and `err_align`=0, and `crc_err_count` increments on the same edge.
- R4: Dribble bits are excluded from the CRC. A frame with 1..7 dribble bits and a passing CRC closes with both error flags 0, and neither counter changes.
- R5: A frame with 1..7 dribble bits and a failing CRC closes with `err_align`=1 and `err_crc`=0, and `align_err_count` increments on the same edge.
- R6: An aligned frame with a passing CRC closes with all flags 0 and both counters unchanged.
- R7: When `accept_short`=0, a frame with `frame_octets` < `min_octets` produces no `done` pulse and changes neither counter. A frame of exactly `min_octets` octets is not short.
- R8: When `accept_short`=1, a short frame closes normally with `short_frame`=1, and its CRC flags and counters follow R3 to R6.
- R9: `hunt` rises on the edge that closes a frame with a failing CRC. It clears on the edge that takes the first bit of the next frame.
- R10: Both counters are CNT_W bits wide (16 by default), advance by one per error, and hold at all ones instead of wrapping.
- R11: After reset, `done`, all flags, both counters and `hunt` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | High for every bit of the frame |
| rx_bit | input | 1 | Received bit, LSB of each octet first |
| min_octets | input | OCT_W | Minimum frame length in octets |
| accept_short | input | 1 | 1 = keep frames below the minimum |
| done | output | 1 | One-cycle frame-close strobe |
| err_crc | output | 1 | CRC error on an aligned frame (with done) |
| err_align | output | 1 | Non-octet-aligned frame with bad CRC (with done) |
| short_frame | output | 1 | Closed frame is below the minimum (with done) |
| frame_octets | output | OCT_W | Whole octets in the last closed frame |
| dribble | output | 3 | Trailing bits past the last octet |
| crc_err_count | output | CNT_W | Saturating CRC error count |
| align_err_count | output | CNT_W | Saturating alignment error count |
| hunt | output | 1 | Waiting for a new frame after a CRC failure |

## Verification
The embedded assertions check the following every cycle:
- `done` is a single-cycle pulse.
- An alignment error is only ever paired with nonzero dribble, and a CRC error only with zero dribble.
- A counter moves only on a strobe carrying its own flag, steps by exactly one, and stays at its ceiling.
- `hunt` rises only with a failing close and falls only when a bit arrives.

Whether the CRC verdict is actually right, the exclusion of dribble bits, and the dropping of short frames can only be shown by the bench. It builds frames with a correct or corrupted check sequence, varies the dribble count and length around the minimum, and compares each strobe and both counters against its own model.

// File: rtl/rxchk_pkg.sv
package rxchk_pkg;
    // Reflected CRC-32 generator and the constant it leaves on an intact frame
    localparam logic [31:0] CRC_POLY_REFL  = 32'hEDB88320;
    localparam logic [31:0] CRC_PRESET     = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_GOOD_RESID = 32'hDEBB20E3;

    // One serial LSB-first step of the reflected CRC
    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic b);
        logic fb;
        logic [31:0] n;
        fb = c[0] ^ b;
        n  = c >> 1;
        if (fb) n = n ^ CRC_POLY_REFL;
        return n;
    endfunction
endpackage

// File: rtl/rxchk_crc_serial.sv
module rxchk_crc_serial
    import rxchk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        bit_en,
    input  logic        bit_in,
    output logic [31:0] crc_next
);
    logic [31:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (bit_en) begin
            crc_d = crc_step(start ? CRC_PRESET : crc_q, bit_in);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= CRC_PRESET;
        else        crc_q <= crc_d;
    end

    assign crc_next = crc_d;
endmodule

// File: rtl/rxchk_bit_len.sv
module rxchk_bit_len #(
    parameter int OCT_W = 14,
    localparam int BIT_W = OCT_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             bit_en,
    output logic [BIT_W-1:0] bits_next,
    output logic [BIT_W-1:0] bits_now
);
    localparam logic [BIT_W-1:0] BITS_MAX = '1;

    logic [BIT_W-1:0] bits_d, bits_q;

    always_comb begin
        bits_d = bits_q;
        if (bit_en) begin
            if (start)                 bits_d = BIT_W'(1);
            else if (bits_q != BITS_MAX) bits_d = bits_q + BIT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    assign bits_next = bits_d;
    assign bits_now  = bits_q;
endmodule

// File: rtl/rxchk_sat_cnt.sv
module rxchk_sat_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] CMAX = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && cnt_q != CMAX) cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    // R10: the count holds once it reaches its ceiling
    a_r10_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q == CMAX |=> cnt_q == CMAX);
    // R10: any change is a single upward step
    a_r10_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q != $past(cnt_q) |-> cnt_q == $past(cnt_q) + W'(1));
endmodule

// File: rtl/rxchk_frame_checker.sv
module rxchk_frame_checker
    import rxchk_pkg::*;
#(
    parameter int OCT_W = 14,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             rx_bit,
    input  logic [OCT_W-1:0] min_octets,
    input  logic             accept_short,
    output logic             done,
    output logic             err_crc,
    output logic             err_align,
    output logic             short_frame,
    output logic [OCT_W-1:0] frame_octets,
    output logic [2:0]       dribble,
    output logic [CNT_W-1:0] crc_err_count,
    output logic [CNT_W-1:0] align_err_count,
    output logic             hunt
);
    localparam int BIT_W = OCT_W + 3;

    typedef struct packed {
        logic             active;
        logic [31:0]      snap;
        logic             done;
        logic             f_crc;
        logic             f_align;
        logic             f_short;
        logic [OCT_W-1:0] octs;
        logic [2:0]       drib;
        logic             hunt;
    } st_t;

    st_t st_d, st_q;

    logic             start, end_evt;
    logic [31:0]      crc_next;
    logic [BIT_W-1:0] bits_next, bits_now;
    logic             inc_crc, inc_align;

    assign start   = rx_valid && !st_q.active;
    assign end_evt = !rx_valid && st_q.active;

    rxchk_crc_serial u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .bit_en   (rx_valid),
        .bit_in   (rx_bit),
        .crc_next (crc_next)
    );

    rxchk_bit_len #(.OCT_W(OCT_W)) u_len (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .bit_en    (rx_valid),
        .bits_next (bits_next),
        .bits_now  (bits_now)
    );

    always_comb begin
        logic [OCT_W-1:0] n_oct;
        logic [2:0]       n_drib;
        logic             crc_bad, is_short, keep;

        n_oct    = bits_now[BIT_W-1:3];
        n_drib   = bits_now[2:0];
        crc_bad  = (st_q.snap != CRC_GOOD_RESID);
        is_short = (n_oct < min_octets);
        keep     = !is_short || accept_short;

        st_d         = st_q;
        st_d.done    = 1'b0;
        st_d.f_crc   = 1'b0;
        st_d.f_align = 1'b0;
        st_d.f_short = 1'b0;
        inc_crc      = 1'b0;
        inc_align    = 1'b0;

        if (rx_valid) begin
            st_d.active = 1'b1;
            if (start) st_d.hunt = 1'b0;
            // Remember the CRC at every whole-octet boundary
            if (bits_next[2:0] == 3'd0) st_d.snap = crc_next;
            else if (start)             st_d.snap = CRC_PRESET;
        end else if (end_evt) begin
            st_d.active = 1'b0;
            if (keep) begin
                st_d.done    = 1'b1;
                st_d.f_crc   = crc_bad && (n_drib == 3'd0);
                st_d.f_align = crc_bad && (n_drib != 3'd0);
                st_d.f_short = is_short;
                st_d.octs    = n_oct;
                st_d.drib    = n_drib;
                inc_crc      = crc_bad && (n_drib == 3'd0);
                inc_align    = crc_bad && (n_drib != 3'd0);
                if (crc_bad) st_d.hunt = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.snap <= CRC_PRESET;
        end else begin
            st_q <= st_d;
        end
    end

    rxchk_sat_cnt #(.W(CNT_W)) u_crc_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (inc_crc),
        .count (crc_err_count)
    );

    rxchk_sat_cnt #(.W(CNT_W)) u_align_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (inc_align),
        .count (align_err_count)
    );

    assign done         = st_q.done;
    assign err_crc      = st_q.f_crc;
    assign err_align    = st_q.f_align;
    assign short_frame  = st_q.f_short;
    assign frame_octets = st_q.octs;
    assign dribble      = st_q.drib;
    assign hunt         = st_q.hunt;

    // R1: the close strobe lasts one cycle
    a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R5: an alignment error always comes with dribble bits
    a_r5_align_has_dribble: assert property (@(posedge clk) disable iff (!rst_n)
        done && err_align |-> dribble != 3'd0);
    // R3: a CRC error is only reported on aligned frames
    a_r3_crc_is_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        done && err_crc |-> dribble == 3'd0);
    // R3: the CRC counter moves only with a CRC-error strobe
    a_r3_crc_count_cause: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err_count != $past(crc_err_count) |-> done && err_crc);
    // R5: the alignment counter moves only with an alignment-error strobe
    a_r5_align_count_cause: assert property (@(posedge clk) disable iff (!rst_n)
        align_err_count != $past(align_err_count) |-> done && err_align);
    // R9: hunt rises only together with a failing close
    a_r9_hunt_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hunt) |-> done && (err_crc || err_align));
    // R9: hunt drops only when a new bit was taken
    a_r9_hunt_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hunt) |-> $past(rx_valid));
endmodule

// File: tb/tb_rxchk_frame_checker.sv
module tb_rxchk_frame_checker;
    localparam int OCT_W = 14;
    localparam int CNT_W = 3;
    localparam int CMAX  = (1 << CNT_W) - 1;

    // 4 time units per period: 250 MHz at 1 ns per unit
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             rst_n = 1'b0;
    logic             rx_valid = 1'b0;
    logic             rx_bit = 1'b0;
    logic [OCT_W-1:0] min_octets = OCT_W'(64);
    logic             accept_short = 1'b0;
    logic             done, err_crc, err_align, short_frame, hunt;
    logic [OCT_W-1:0] frame_octets;
    logic [2:0]       dribble;
    logic [CNT_W-1:0] crc_err_count, align_err_count;

    rxchk_frame_checker #(.OCT_W(OCT_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_bit(rx_bit),
        .min_octets(min_octets), .accept_short(accept_short),
        .done(done), .err_crc(err_crc), .err_align(err_align),
        .short_frame(short_frame), .frame_octets(frame_octets),
        .dribble(dribble), .crc_err_count(crc_err_count),
        .align_err_count(align_err_count), .hunt(hunt)
    );

    typedef struct {
        bit    e_crc;
        bit    e_align;
        bit    e_short;
        int    octs;
        int    drib;
        string req;
    } exp_t;

    exp_t expq[$];
    int total = 0;
    int bad = 0;
    int done_seen = 0;
    int exp_done = 0;
    int exp_crc_cnt = 0;
    int exp_al_cnt = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_crc(input byte unsigned d[$]);
        logic [31:0] c = 32'hFFFF_FFFF;
        foreach (d[k]) begin
            for (int i = 0; i < 8; i++) begin
                logic fb;
                fb = c[0] ^ d[k][i];
                c  = {1'b0, c[31:1]};
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        return c;
    endfunction

    // Monitor: pops the scoreboard on every close strobe
    always @(negedge clk) begin
        if (rst_n && done) begin
            done_seen++;
            if (expq.size() == 0) begin
                chk(1'b0, "R7", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                chk(frame_octets == OCT_W'(e.octs), "R1", {e.req, " octets"}, int'(frame_octets), e.octs);
                chk(dribble == 3'(e.drib), "R1", {e.req, " dribble"}, int'(dribble), e.drib);
                chk(err_crc == e.e_crc, "R2/R3", {e.req, " err_crc"}, int'(err_crc), int'(e.e_crc));
                chk(err_align == e.e_align, "R4/R5", {e.req, " err_align"}, int'(err_align), int'(e.e_align));
                chk(short_frame == e.e_short, "R8", {e.req, " short_frame"}, int'(short_frame), int'(e.e_short));
            end
        end
    end

    // Driver: builds a frame, predicts the result, shifts it in and checks the aftermath
    task automatic send(input int n_pay, input int drib, input bit corrupt,
                        input int seed, input string req);
        byte unsigned fr[$];
        logic [31:0] fcs;
        int octs, nbits;
        bit is_short, keep;
        exp_t e;
        for (int i = 0; i < n_pay; i++) fr.push_back(8'((seed + i * 7) ^ (i >> 3)));
        fcs = ~model_crc(fr);
        for (int i = 0; i < 4; i++) fr.push_back(fcs[8*i +: 8]);
        if (corrupt) fr[2] = fr[2] ^ 8'h10;
        octs     = n_pay + 4;
        is_short = octs < int'(min_octets);
        keep     = !is_short || accept_short;
        if (keep) begin
            e.e_crc   = corrupt && drib == 0;
            e.e_align = corrupt && drib != 0;
            e.e_short = is_short;
            e.octs    = octs;
            e.drib    = drib;
            e.req     = req;
            expq.push_back(e);
            exp_done++;
            if (e.e_crc && exp_crc_cnt < CMAX) exp_crc_cnt++;
            if (e.e_align && exp_al_cnt < CMAX) exp_al_cnt++;
        end
        nbits = octs * 8 + drib;
        for (int b = 0; b < nbits; b++) begin
            @(negedge clk);
            if (b == 1) chk(hunt == 1'b0, "R9", {req, " hunt cleared by frame start"}, int'(hunt), 0);
            rx_valid = 1'b1;
            rx_bit   = (b < octs * 8) ? fr[b / 8][b % 8] : 1'(b & 1);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_bit   = 1'b0;
        repeat (3) @(negedge clk);
        chk(done_seen == exp_done, "R7", {req, " strobe count"}, done_seen, exp_done);
        chk(int'(crc_err_count) == exp_crc_cnt, "R10", {req, " crc count"}, int'(crc_err_count), exp_crc_cnt);
        chk(int'(align_err_count) == exp_al_cnt, "R10", {req, " align count"}, int'(align_err_count), exp_al_cnt);
        chk(hunt == (keep && corrupt), "R9", {req, " hunt after close"}, int'(hunt), int'(keep && corrupt));
        chk(expq.size() == 0, "R1", {req, " pending results"}, expq.size(), 0);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            chk(1'b0, "WDOG", "watchdog expired", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: state while and right after reset
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0 && err_crc == 1'b0 && err_align == 1'b0 && short_frame == 1'b0,
            "R11", "strobe and flags", int'({done, err_crc, err_align, short_frame}), 0);
        chk(crc_err_count == '0 && align_err_count == '0, "R11", "counters",
            int'(crc_err_count) + int'(align_err_count), 0);
        chk(hunt == 1'b0, "R11", "hunt", int'(hunt), 0);

        send(60, 0, 1'b0, 11, "R6 good aligned min length");
        send(60, 3, 1'b0, 23, "R4 good with 3 dribble");
        send(60, 7, 1'b0, 31, "R4 good with 7 dribble");
        send(60, 0, 1'b1, 41, "R3 bad aligned");
        send(100, 0, 1'b0, 53, "R9 good after hunt");
        send(60, 5, 1'b1, 67, "R5 bad with 5 dribble");
        send(59, 0, 1'b0, 71, "R7 short good dropped");
        send(59, 0, 1'b1, 79, "R7 short bad dropped");
        send(60, 1, 1'b1, 83, "R5 bad with 1 dribble");
        accept_short = 1'b1;
        send(20, 0, 1'b0, 91, "R8 short kept good");
        send(20, 2, 1'b1, 97, "R8 short kept bad");
        accept_short = 1'b0;
        for (int i = 0; i < 9; i++) send(60, 0, 1'b1, 100 + i, "R10 crc saturate");
        for (int i = 0; i < 6; i++) send(60, 6, 1'b1, 200 + i, "R10 align saturate");
        send(60, 0, 1'b0, 300, "R6 good after saturation");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule